// File: doc/BRIEF.md
# Active Interrupt Number Resolver

This block turns three pending-status words into one interrupt number for the handler to service next. The three words are a 21-bit top-level word and two 32-bit bank words. Global numbers run from 0 to 71. The eight top-level sources take numbers 0 to 7. Bank-1 bit k takes number 8+k, and bank-2 bit k takes number 40+k.

The pick is not a flat priority encoder. It works in a fixed order of stages:

1. The top-level sources.
2. A set of shortcut bits in the top-level word. Each one mirrors a chosen bank bit and is tried in a fixed list order.
3. A lowest-first scan of each bank. Bits that already have a shortcut are left out of the scan.

The result and a valid flag are registered once per clock. Sources clear themselves, and there is no register bus.

Top module: `irq_resolver`

## Requirements
- R1: Numbering: top-level bit i (i in 0..7) maps to number i, bank-1 bit k maps to 8+k, and bank-2 bit k maps to 40+k. A valid number is always below 72.
- R2: When all 21 bits of `basic_pend` are zero, `irq_valid` is low.
- R3: If any of `basic_pend[7:0]` is set, the output is the index of the lowest set bit among them. This stage beats every other stage.
- R4: Otherwise, `basic_pend[14:10]` are shortcuts for bank-1 bits 7, 9, 10, 18 and 19, in that order. The first one set in that order gives 15, 17, 18, 26 or 27.
- R5: Otherwise, `basic_pend[20:15]` are shortcuts for bank-2 bits 21, 22, 23, 24, 25 and 30, in that order. The first one set gives 61, 62, 63, 64, 65 or 70. Every bank-1 shortcut beats every bank-2 shortcut.
- R6: Otherwise, if `basic_pend[8]` (bank-1 summary) is set, the output is 8 plus the lowest set bit of `bank1_pend` after bits 7, 9, 10, 18 and 19 are cleared.
- R7: Otherwise, if `basic_pend[9]` (bank-2 summary) is set, the output is 40 plus the lowest set bit of `bank2_pend` after bits 21 to 25 and 30 are cleared.
- R8: A summary whose masked scan is empty yields nothing. An empty bank-1 scan falls through to the bank-2 stage. If that stage is also empty, `irq_valid` is low.
- R9: Outputs are registered on the rising edge, so the result for inputs held before an edge appears after that edge. A synchronous active-low reset makes the outputs not-valid with number zero.
- R10: While `irq_valid` is low, `irq_num` is zero.
- R11: A bank word has no effect while its summary bit is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| basic_pend | input | 21 | Top-level sources [7:0], summaries [9:8], shortcuts [20:10] |
| bank1_pend | input | 32 | Bank-1 pending bits |
| bank2_pend | input | 32 | Bank-2 pending bits |
| irq_num | output | 7 | Selected global interrupt number, zero when not valid |
| irq_valid | output | 1 | A number was selected |

## Verification
The properties assume the inputs are sampled as stable one clock before the result is checked. They make no assumption that a shortcut bit agrees with its mirrored bank bit, so any combination of inputs is legal. The stimulus changes inputs only on the falling edge, and it deliberately drives shortcut bits with their bank bits both set and cleared. Random patterns are thinned, by combining several random words with AND, so that later stages are reached as well as the top-level stage.

// File: rtl/irq_res_pkg.sv
// Package irq_res_pkg
// Shared constants for the interrupt number resolver: widths, bank bases,
// the position of summary and shortcut bits inside the top-level word, and
// the shortcut tables (8-bit entries, entry 0 in the low byte).
package irq_res_pkg;
    parameter int NUM_W      = 7;
    parameter int BASIC_N    = 8;
    parameter int BANK_W     = 32;
    parameter int PEND_W     = 21;
    parameter int B1_BASE    = BASIC_N;
    parameter int B2_BASE    = BASIC_N + BANK_W;
    parameter int SUM1_POS   = 8;
    parameter int SUM2_POS   = 9;
    parameter int SC1_N      = 5;
    parameter int SC2_N      = 6;
    parameter int SC1_POS    = 10;
    parameter int SC2_POS    = SC1_POS + SC1_N;
    parameter logic [8*SC1_N-1:0] SC1_TAB = {8'd19, 8'd18, 8'd10, 8'd9, 8'd7};
    parameter logic [8*SC2_N-1:0] SC2_TAB = {8'd30, 8'd25, 8'd24, 8'd23, 8'd22, 8'd21};

    typedef logic [NUM_W-1:0] irq_num_t;

    // Build the bank exclusion mask from a shortcut table.
    function automatic logic [BANK_W-1:0] tab_to_mask(logic [63:0] tab, int n);
        logic [BANK_W-1:0] m;
        m = '0;
        for (int i = 0; i < n; i++) begin
            m[int'(tab[i*8 +: 8])] = 1'b1;
        end
        return m;
    endfunction

    parameter logic [BANK_W-1:0] EXCL1 = tab_to_mask(64'(SC1_TAB), SC1_N);
    parameter logic [BANK_W-1:0] EXCL2 = tab_to_mask(64'(SC2_TAB), SC2_N);
endpackage

// File: rtl/irq_lsb_scan.sv
// Module irq_lsb_scan
// Finds the lowest set bit of a vector after removing the bits in EXCL and
// returns BASE plus its index. Purely combinational.
// Assumes BASE + W - 1 fits in NUM_W bits.
module irq_lsb_scan #(
    parameter int W = 32,
    parameter int BASE = 0,
    parameter int NUM_W = 7,
    parameter logic [W-1:0] EXCL = '0
) (
    input  logic [W-1:0]     vec,
    output logic             found,
    output logic [NUM_W-1:0] num
);
    logic [W-1:0] kept;

    // Downward sweep so the lowest set bit is written last.
    always_comb begin
        kept  = vec & ~EXCL;
        found = 1'b0;
        num   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (kept[i]) begin
                found = 1'b1;
                num   = NUM_W'(BASE + i);
            end
        end
    end
endmodule

// File: rtl/irq_shortcut_pick.sv
// Module irq_shortcut_pick
// Picks the first set shortcut in list order and maps it to BASE plus the
// bank bit that the table names for it. Purely combinational.
// Assumes each table entry is below the bank width.
module irq_shortcut_pick #(
    parameter int N = 5,
    parameter int BASE = 8,
    parameter int NUM_W = 7,
    parameter logic [8*N-1:0] TAB = '0
) (
    input  logic [N-1:0]     hit,
    output logic             found,
    output logic [NUM_W-1:0] num
);
    // Walk from the last entry down so the earliest listed entry wins.
    always_comb begin
        found = 1'b0;
        num   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) begin
                found = 1'b1;
                num   = NUM_W'(BASE + int'(TAB[i*8 +: 8]));
            end
        end
    end
endmodule

// File: rtl/irq_resolver.sv
// Module irq_resolver
// Resolves one global interrupt number (0..71) from the top-level pending
// word and two bank words. The stages run in order: top-level sources,
// bank-1 shortcuts, bank-2 shortcuts, bank-1 scan, bank-2 scan.
// The result is registered; the reset is synchronous and active low.
// Assumes the inputs are already masked by their enables.
module irq_resolver
    import irq_res_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PEND_W-1:0] basic_pend,
    input  logic [BANK_W-1:0] bank1_pend,
    input  logic [BANK_W-1:0] bank2_pend,
    output logic [NUM_W-1:0]  irq_num,
    output logic              irq_valid
);
    localparam int STAGES = 5;

    logic     [STAGES-1:0] hit;
    irq_num_t              cand [STAGES];
    logic                  nxt_valid;
    irq_num_t              nxt_num;

    irq_lsb_scan #(.W(BASIC_N), .BASE(0), .NUM_W(NUM_W), .EXCL('0)) u_basic (
        .vec(basic_pend[BASIC_N-1:0]), .found(hit[0]), .num(cand[0]));

    irq_shortcut_pick #(.N(SC1_N), .BASE(B1_BASE), .NUM_W(NUM_W), .TAB(SC1_TAB)) u_sc1 (
        .hit(basic_pend[SC1_POS +: SC1_N]), .found(hit[1]), .num(cand[1]));

    irq_shortcut_pick #(.N(SC2_N), .BASE(B2_BASE), .NUM_W(NUM_W), .TAB(SC2_TAB)) u_sc2 (
        .hit(basic_pend[SC2_POS +: SC2_N]), .found(hit[2]), .num(cand[2]));

    logic scan1_found, scan2_found;

    irq_lsb_scan #(.W(BANK_W), .BASE(B1_BASE), .NUM_W(NUM_W), .EXCL(EXCL1)) u_bank1 (
        .vec(bank1_pend), .found(scan1_found), .num(cand[3]));

    irq_lsb_scan #(.W(BANK_W), .BASE(B2_BASE), .NUM_W(NUM_W), .EXCL(EXCL2)) u_bank2 (
        .vec(bank2_pend), .found(scan2_found), .num(cand[4]));

    // A bank scan counts only when its summary bit is set.
    always_comb begin
        hit[3] = basic_pend[SUM1_POS] & scan1_found;
        hit[4] = basic_pend[SUM2_POS] & scan2_found;
    end

    // Fixed stage order: the lowest stage index with a hit wins.
    always_comb begin
        nxt_valid = 1'b0;
        nxt_num   = '0;
        for (int s = STAGES - 1; s >= 0; s--) begin
            if (hit[s]) begin
                nxt_valid = 1'b1;
                nxt_num   = cand[s];
            end
        end
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_num   <= '0;
        end else begin
            irq_valid <= nxt_valid;
            irq_num   <= nxt_num;
        end
    end
endmodule

// File: rtl/irq_resolver_chk.sv
// Module irq_resolver_chk
// Temporal checks on the resolver ports, attached by bind.
// Assumes the inputs are stable across each rising edge.
module irq_resolver_chk
    import irq_res_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [PEND_W-1:0] basic_pend,
    input logic [BANK_W-1:0] bank1_pend,
    input logic [BANK_W-1:0] bank2_pend,
    input logic [NUM_W-1:0]  irq_num,
    input logic              irq_valid
);
    p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_num < 7'd72));

    p_quiet_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (basic_pend == '0) |=> !irq_valid);

    p_basic_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|basic_pend[7:0]) |=> (irq_valid && irq_num < 7'd8));

    p_bit0_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        basic_pend[0] |=> (irq_num == 7'd0));

    p_first_shortcut_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (basic_pend[7:0] == 8'h00 && basic_pend[10]) |=> (irq_valid && irq_num == 7'd15));

    p_bank2_scan_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (basic_pend == 21'h000200 && bank2_pend[0]) |=> (irq_valid && irq_num == 7'd40));

    p_empty_summary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (basic_pend == 21'h000100 && (bank1_pend & ~EXCL1) == '0) |=> !irq_valid);

    p_reset_clears_r9: assert property (@(posedge clk)
        !rst_n |=> (!irq_valid && irq_num == '0));

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_num == '0));
endmodule

bind irq_resolver irq_resolver_chk u_chk (.*);

// File: tb/tb_irq_resolver.sv
module tb_irq_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [20:0] basic_pend = '0;
    logic [31:0] bank1_pend = '0;
    logic [31:0] bank2_pend = '0;
    logic [6:0]  irq_num;
    logic        irq_valid;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        logic       v;
        logic [6:0] n;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;   // 50 MHz

    irq_resolver dut (.*);

    // Reference pick written from the requirements.
    function automatic logic [7:0] ref_pick(logic [20:0] bp, logic [31:0] p1, logic [31:0] p2);
        int s1[5] = '{7, 9, 10, 18, 19};
        int s2[6] = '{21, 22, 23, 24, 25, 30};
        logic [31:0] m;
        for (int i = 0; i < 8; i++) if (bp[i]) return {1'b1, 7'(i)};
        for (int i = 0; i < 5; i++) if (bp[10 + i]) return {1'b1, 7'(8 + s1[i])};
        for (int i = 0; i < 6; i++) if (bp[15 + i]) return {1'b1, 7'(40 + s2[i])};
        if (bp[8]) begin
            m = p1;
            for (int i = 0; i < 5; i++) m[s1[i]] = 1'b0;
            for (int k = 0; k < 32; k++) if (m[k]) return {1'b1, 7'(8 + k)};
        end
        if (bp[9]) begin
            m = p2;
            for (int i = 0; i < 6; i++) m[s2[i]] = 1'b0;
            for (int k = 0; k < 32; k++) if (m[k]) return {1'b1, 7'(40 + k)};
        end
        return 8'h00;
    endfunction

    // Driver: apply on the falling edge and queue the expectation.
    task automatic drive(input logic [20:0] bp, input logic [31:0] p1, input logic [31:0] p2,
                         input string tag, input logic chk_v, input logic [6:0] chk_n);
        logic [7:0] r;
        exp_t e;
        @(negedge clk);
        basic_pend = bp; bank1_pend = p1; bank2_pend = p2;
        r = ref_pick(bp, p1, p2);
        if (r[7] !== chk_v || (chk_v && r[6:0] !== chk_n))
            $display("NOTE reference disagrees with hand value for %s", tag);
        e.v = chk_v; e.n = chk_v ? chk_n : 7'd0; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drive_ref(input logic [20:0] bp, input logic [31:0] p1, input logic [31:0] p2);
        logic [7:0] r;
        r = ref_pick(bp, p1, p2);
        drive(bp, p1, p2, "R1 random", r[7], r[6:0]);
    endtask

    // Monitor: one register stage, so compare just after the next rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_run++;
                if (irq_valid !== e.v || irq_num !== e.n) begin
                    n_fail++;
                    $display("FAIL %s: got v=%0b n=%0d, expected v=%0b n=%0d",
                             e.tag, irq_valid, irq_num, e.v, e.n);
                end
            end
        end
    end

    task automatic check_direct(input string tag, input logic v, input logic [6:0] n);
        n_run++;
        if (irq_valid !== v || irq_num !== n) begin
            n_fail++;
            $display("FAIL %s: got v=%0b n=%0d, expected v=%0b n=%0d", tag, irq_valid, irq_num, v, n);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 check_direct("R9 reset state", 1'b0, 7'd0);
        @(negedge clk) rst_n = 1'b1;

        drive(21'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 R11 quiet with full banks", 1'b0, 0);
        drive(21'h0000A, 0, 0, "R3 lowest basic", 1'b1, 1);
        drive(21'h1FFF80, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 basic beats all", 1'b1, 7);
        drive(21'h03000, 0, 0, "R4 shortcut order", 1'b1, 18);
        drive(21'h07C00, 0, 0, "R4 first shortcut", 1'b1, 15);
        drive(21'h04000, 0, 0, "R4 last shortcut", 1'b1, 27);
        drive(21'h100000, 0, 0, "R5 bank2 bit30 shortcut", 1'b1, 70);
        drive(21'h110000, 0, 0, "R5 bank2 order", 1'b1, 62);
        drive(21'h08800, 0, 0, "R5 bank1 shortcut beats bank2", 1'b1, 17);
        drive(21'h00100, 32'h0000_0088, 0, "R6 shortcut bit excluded", 1'b1, 11);
        drive(21'h00100, 32'h800C_0600, 0, "R6 high bank1 bit", 1'b1, 39);
        drive(21'h00200, 0, 32'h0420_0000, "R7 excluded then 26", 1'b1, 66);
        drive(21'h00300, 32'h0000_0001, 32'h0000_0001, "R7 bank1 scan first", 1'b1, 8);
        drive(21'h00100, 32'h000C_0680, 32'h8000_0000, "R8 empty bank1 scan", 1'b0, 0);
        drive(21'h00300, 32'h000C_0680, 32'h8000_0000, "R8 fall through to bank2", 1'b1, 71);
        drive(21'h00200, 0, 32'h7E00_0000 & 32'h43E0_0000, "R8 empty bank2 scan", 1'b0, 0);
        drive(21'h00200, 32'hFFFF_FFFF, 32'h0000_0001, "R11 bank1 ignored", 1'b1, 40);
        drive(21'h00100, 32'h0000_0010, 32'hFFFF_FFFF, "R11 bank2 ignored", 1'b1, 12);
        drive(21'h00000, 32'h1, 32'h1, "R10 idle number zero", 1'b0, 0);

        for (int i = 0; i < 300; i++) begin
            logic [20:0] bp;
            bp = 21'($urandom & $urandom & $urandom);
            if (i % 3 == 0) bp[7:0] = '0;
            if (i % 3 == 1) bp[20:0] = bp & 21'h00300;
            drive_ref(bp, $urandom & $urandom, $urandom & $urandom);
        end

        @(negedge clk);
        basic_pend = 21'h1;
        rst_n = 1'b0;
        @(posedge clk);
        #1 check_direct("R9 reset mid-run", 1'b0, 7'd0);
        @(negedge clk) rst_n = 1'b1;
        drive(21'h00004, 0, 0, "R9 after reset", 1'b1, 2);
        repeat (3) @(posedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R9 watchdog: got hang, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule